// File: doc/BRIEF.md
# PWM DAC Duty-Cycle Generator

This block turns a stream of unsigned 12-bit samples into a pulse-width-modulated pin. The average level of the pin follows the sample, so an external low-pass filter can turn it into a simple DAC. A free-running 5-bit counter sets a 32-clock carrier. The sample is read as a fraction in [0,1). Its coarse part becomes a whole-clock high time, and its fine part becomes a sub-clock edge-delay step count. That step count drives an external fine-delay element.

A sample is taken into a shadow register on a load strobe. The shadow is moved into the active compare and fine-step registers only on the clock edge where the counter goes from 31 to 0. Each period is therefore built wholly from one sample. The number of fine steps per clock is held in a writable scale register, because the delay of a real fine step drifts with temperature and supply voltage.

Top module: `pwm_dac_gen`

## Requirements
- R1: Only bits 11:0 of `sample_in` are taken as the sample, and bits 15:12 have no effect on `pwm_out` or `fine_step`.
- R2: The period is 32 clocks, counted by a counter that runs 0 to 31 and wraps. The integer compare is (32 × sample) >> 12. `pwm_out` is high in the cycles whose count is below the compare and low in the rest, so a compare of 0 gives a constantly low pin.
- R3: The duty fraction is always below one. With sample 4095, the pin is high for 31 cycles and low in the cycle with count 31.
- R4: `fine_step` equals (F × S) >> 7. Here F is the 7-bit Q7 fraction just below the integer part (sample bits 6:0), and S is the scale register.
- R5: The scale register resets to 111 and is loaded from `scale_in` when `scale_wr` is high. A new scale takes effect only from the next period boundary.
- R6: A `sample_load` strobe captures the sample into the shadow register. The active compare and fine step change only at the 31-to-0 wrap, so a load made during a period leaves the rest of that period unchanged. A load on the wrap edge itself is applied one period later.
- R7: `fine_step` holds one value for all 32 cycles of a period.
- R8: While `rst` is high, `pwm_out` is low in the same cycle. After a reset edge, `fine_step` is 0, the counter is 0, the shadow is cleared and the scale is back to 111.
- R9: After reset is released, the counter reads 0 in the first cycle and advances by one per clock. The first period uses a compare of 0, so the pin stays low throughout it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 16 | Sample word; the low 12 bits hold the unsigned sample |
| sample_load | input | 1 | Captures `sample_in` into the shadow register |
| scale_wr | input | 1 | Loads `scale_in` into the steps-per-clock register |
| scale_in | input | 8 | New steps-per-clock value |
| pwm_out | output | 1 | Modulated output pin |
| fine_step | output | 8 | Sub-clock edge-delay step count for the current period |

## Verification
The assertions rely on `rst` being synchronous and free of glitches. They also rely on the counter starting from 0 after each release, which is why the bench keeps its own phase count cleared by the same reset. The compare and step checks assume that the sample and the scale change only through their strobes. The stimulus therefore drives strobes on the falling edge, holds them for one clock, and avoids the wrap edge unless a test targets that edge on purpose.

// File: rtl/pwm_dac_gen.sv
module pwm_dac_gen #(
  parameter int PERIOD_BITS = 5,
  parameter int SAMPLE_BITS = 12,
  parameter int WORD_BITS   = 16,
  parameter int FRAC_BITS   = 7,
  parameter int SCALE_BITS  = 8,
  parameter int SCALE_RESET = 111
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_BITS-1:0]  sample_in,
  input  logic                  sample_load,
  input  logic                  scale_wr,
  input  logic [SCALE_BITS-1:0] scale_in,
  output logic                  pwm_out,
  output logic [SCALE_BITS-1:0] fine_step
);

  localparam int PERIOD    = 1 << PERIOD_BITS;
  localparam int PROD_BITS = SAMPLE_BITS + PERIOD_BITS + 1;
  localparam int MUL_BITS  = FRAC_BITS + SCALE_BITS;

  logic [PERIOD_BITS-1:0] cnt, cmp_q, cmp_d;
  logic [SAMPLE_BITS-1:0] shadow;
  logic [SCALE_BITS-1:0]  scale_q, fine_d;
  logic [PROD_BITS-1:0]   prod;
  logic [FRAC_BITS-1:0]   frac;
  logic [MUL_BITS-1:0]    fine_prod;
  logic                   wrap;

  assign wrap      = (cnt == PERIOD_BITS'(PERIOD - 1));
  assign prod      = PROD_BITS'(PERIOD) * PROD_BITS'(shadow);
  assign cmp_d     = PERIOD_BITS'(prod >> SAMPLE_BITS);
  assign frac      = FRAC_BITS'(prod >> (SAMPLE_BITS - FRAC_BITS));
  assign fine_prod = MUL_BITS'(frac) * MUL_BITS'(scale_q);
  assign fine_d    = SCALE_BITS'(fine_prod >> FRAC_BITS);
  assign pwm_out   = !rst && (cnt < cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      shadow    <= '0;
      cmp_q     <= '0;
      fine_step <= '0;
      scale_q   <= SCALE_BITS'(SCALE_RESET);
    end else begin
      cnt <= cnt + 1'b1;
      if (sample_load) shadow  <= SAMPLE_BITS'(sample_in);
      if (scale_wr)    scale_q <= scale_in;
      if (wrap) begin
        cmp_q     <= cmp_d;
        fine_step <= fine_d;
      end
    end
  end

  // R3
  full_period_low_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !pwm_out);

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(cmp_q));

  // R7
  fine_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(fine_step));

  // R8
  rst_low_chk: assert property (@(posedge clk)
    rst |-> !pwm_out);

  // R8
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fine_step == '0 && cnt == '0));

  // R9
  first_cycle_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pwm_out);

endmodule

// File: tb/pwm_dac_gen_tb.sv
module pwm_dac_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sample_in = '0;
  logic        sample_load = 1'b0;
  logic        scale_wr = 1'b0;
  logic [7:0]  scale_in = '0;
  logic        pwm_out;
  logic [7:0]  fine_step;
  logic [4:0]  bcnt = '0;
  int checks = 0;
  int errors = 0;
  int cur_scale = 111;
  bit done = 1'b0;

  pwm_dac_gen u_dut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .sample_load(sample_load),
    .scale_wr(scale_wr), .scale_in(scale_in), .pwm_out(pwm_out), .fine_step(fine_step)
  );

  always #5 clk = ~clk;
  always @(posedge clk) bcnt <= rst ? 5'd0 : bcnt + 5'd1;

  function automatic int exp_cmp(input int s);
    return (32 * (s & 4095)) >> 12;
  endfunction

  function automatic int exp_fine(input int s, input int sc);
    return ((s & 127) * sc) >> 7;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_start();
    do @(negedge clk); while (bcnt != 5'd0);
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    while (bcnt == 5'd31) @(negedge clk);
    sample_in = v; sample_load = 1'b1;
    @(negedge clk);
    sample_load = 1'b0;
  endtask

  task automatic watch(input int first, input int last, input int cmp_e, input int fine_e,
                       inout int bad_pwm, inout int bad_fine, inout int highs);
    for (int i = first; i <= last; i++) begin
      if (i != first) @(negedge clk);
      if (pwm_out) highs++;
      if (pwm_out !== (i < cmp_e)) bad_pwm++;
      if (fine_step !== fine_e[7:0]) bad_fine++;
    end
  endtask

  task automatic period_test(input logic [15:0] v, input string req);
    int bp = 0, bf = 0, hi = 0;
    int c = exp_cmp(int'(v));
    int f = exp_fine(int'(v), cur_scale);
    load(v);
    to_start();
    watch(0, 31, c, f, bp, bf, hi);
    check(bp == 0 && hi == c, {req, " pwm high cycles"}, hi, c);
    check(bf == 0, {req, " R7 fine_step mismatched cycles"}, bf, 0);
    check(fine_step == f[7:0], {req, " fine_step"}, fine_step, f);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(pwm_out == 1'b0, "R8 pwm during reset", pwm_out, 0);
      check(fine_step == 8'd0, "R8 fine_step during reset", fine_step, 0);
    end
    rst = 1'b0;
  endtask

  task automatic t_first_period();
    int bp = 0, bf = 0, hi = 0;
    @(negedge clk);
    watch(1, 31, 0, 0, bp, bf, hi);
    check(bp == 0, "R9 first period low", hi, 0);
  endtask

  task automatic t_values();
    period_test(16'd0,    "R2 zero sample");
    period_test(16'd2048, "R2 R4 half scale");
    period_test(16'd1000, "R2 R4 sample 1000");
    period_test(16'd4095, "R3 R5 full scale default scale");
    period_test(16'd127,  "R4 fraction only");
  endtask

  task automatic t_upper();
    period_test(16'hF064, "R1 upper bits set");
    check(exp_cmp(16'h0064) == 0, "R1 expected compare", exp_cmp(16'h0064), 0);
  endtask

  task automatic t_shadow();
    int bp = 0, bf = 0, hi = 0;
    load(16'd3000);
    to_start();
    watch(0, 10, exp_cmp(3000), exp_fine(3000, cur_scale), bp, bf, hi);
    sample_in = 16'd500; sample_load = 1'b1;
    @(negedge clk);
    sample_load = 1'b0;
    watch(11, 31, exp_cmp(3000), exp_fine(3000, cur_scale), bp, bf, hi);
    check(bp == 0 && bf == 0, "R6 mid-period load ignored", bp + bf, 0);
    bp = 0; bf = 0; hi = 0;
    to_start();
    watch(0, 31, exp_cmp(500), exp_fine(500, cur_scale), bp, bf, hi);
    check(bp == 0 && bf == 0, "R6 load applied next period", fine_step, exp_fine(500, cur_scale));
  endtask

  task automatic t_wrap_load();
    int bp = 0, bf = 0, hi = 0;
    load(16'd1024);
    do @(negedge clk); while (bcnt != 5'd31);
    sample_in = 16'd3584; sample_load = 1'b1;
    @(negedge clk);
    sample_load = 1'b0;
    watch(0, 31, exp_cmp(1024), exp_fine(1024, cur_scale), bp, bf, hi);
    check(bp == 0 && bf == 0, "R6 wrap-edge load deferred", hi, exp_cmp(1024));
    bp = 0; bf = 0; hi = 0;
    to_start();
    watch(0, 31, exp_cmp(3584), exp_fine(3584, cur_scale), bp, bf, hi);
    check(bp == 0 && bf == 0, "R6 wrap-edge load then applied", hi, exp_cmp(3584));
  endtask

  task automatic t_scale();
    int bp = 0, bf = 0, hi = 0;
    load(16'd4095);
    to_start();
    watch(0, 5, 31, exp_fine(4095, 111), bp, bf, hi);
    scale_in = 8'd200; scale_wr = 1'b1;
    @(negedge clk);
    scale_wr = 1'b0;
    watch(6, 31, 31, exp_fine(4095, 111), bp, bf, hi);
    check(bp == 0 && bf == 0, "R5 scale write waits for boundary", fine_step, exp_fine(4095, 111));
    cur_scale = 200;
    to_start();
    check(fine_step == 8'(exp_fine(4095, 200)), "R5 R4 scale 200", fine_step, exp_fine(4095, 200));
    period_test(16'd1000, "R4 R5 scale 200 sample 1000");
  endtask

  task automatic t_reset_mid();
    int bp = 0, bf = 0, hi = 0;
    load(16'd4095);
    to_start();
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b1;
    #1;
    check(pwm_out == 1'b0, "R8 pwm low same cycle as reset", pwm_out, 0);
    @(negedge clk);
    check(fine_step == 8'd0, "R8 fine_step cleared", fine_step, 0);
    rst = 1'b0;
    cur_scale = 111;
    @(negedge clk);
    watch(1, 31, 0, 0, bp, bf, hi);
    check(bp == 0 && bf == 0, "R8 R9 low after reset", hi, 0);
    period_test(16'd4095, "R8 scale back to 111");
  endtask

  initial begin
    t_reset();
    t_first_period();
    t_values();
    t_upper();
    t_shadow();
    t_wrap_load();
    t_scale();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule